// File: doc/BRIEF.md
# Serial-Bus Status Register with Pin-Gated Write Lock

This block is the serial slave that reaches a small control register. The register holds a two-bit watchdog period, two block-protect bits and a lock-enable bit. An SPI master selects the block with an active-low select. It sends a one-byte command and, for the two commands that carry data, reads or writes one status byte. The block runs on a fast system clock. It samples SCK, chip select and the serial input on every system clock edge and acts on SCK transitions. SPI modes 0 and 3 both work unchanged.

A status write succeeds only after a write-enable command has set the write-enable latch. Every status write clears the latch. The register is frozen when the lock-enable bit is set and the active-low protect pin is driven low. The block drops any byte that chip select cuts short. It ignores traffic until chip select has fallen once since reset, and it ignores traffic while the system reset flag is high. The register fields are driven straight out to the watchdog and protection logic.

Top module: `spi_status_lock`

## Requirements
- R1: After reset the watchdog period is 2'b11 (watchdog off), block protect is 2'b00, lock enable is 0, the write-enable latch is 0 and `so_oe` is 0.
- R2: SI is taken on SCK rising edges and SO changes on SCK falling edges, MSB first, in SPI mode 0 (SCK idles low) and in mode 3 (SCK idles high).
- R3: Command 0x06 sets the write-enable latch. Command 0x04 clears it.
- R4: Command 0x05 returns the status byte: bit 7 = lock enable, bit 6 = 0, bits 5:4 = watchdog period, bits 3:2 = block protect, bit 1 = write-enable latch, bit 0 = 0 (no write in progress). The byte repeats for as long as SCK keeps running with chip select low.
- R5: Command 0x01 followed by a data byte loads bit 7 into lock enable, bits 5:4 into the watchdog period and bits 3:2 into block protect, but only if the write-enable latch is set. The command always clears the latch. With the latch clear, the fields do not change.
- R6: While `wp_n` is low and lock enable is 1, a status write leaves all three fields unchanged, but it still clears the latch. With `wp_n` high, or with lock enable 0, the write goes through.
- R7: `so_oe` is high only in the read-data phase of a 0x05 command while `csn` is low. With `csn` high the block is idle and no field changes.
- R8: After reset, nothing is decoded until `csn` has gone from high to low. Bits clocked while `csn` was already low at reset release have no effect.
- R9: While `sys_rst` is high, the block decodes nothing, aborts any transaction in progress and keeps `so_oe` low. Traffic resumes only at the next `csn` falling edge.
- R10: If `csn` rises before a command or data byte is complete, that byte changes no register and no latch.
- R11: Any other command byte is ignored, and the rest of that transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low protect pin |
| sys_rst | input | 1 | High while system reset is asserted; blocks all traffic |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (tri-state control) |
| wp_en | output | 1 | Lock-enable bit |
| wdt_period | output | 2 | Watchdog period field |
| blk_prot | output | 2 | Block-protect field |

## Verification
The bench uses the default parameters: an 8-bit frame, a reset watchdog code of 2'b11 and a reset protect code of 2'b00. The reset test therefore checks the watchdog-off state, and every one of the five status bits that a write can reach is driven to both values. Each SCK level is held for two system clocks, so the bench sees every edge-detect path in the serial engine. A byte count of 8 is small enough to cut a frame after four data bits or five command bits. That exercises the discard path and the wrap of the status read into a repeated byte.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int FRAME_W = 8;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_WRDI = 8'h04;
    localparam logic [7:0] CMD_RDSR = 8'h05;
    localparam logic [7:0] CMD_WRSR = 8'h01;

    // bit positions inside the status byte, shared by read and write paths
    localparam int POS_LOCK = 7;
    localparam int POS_WDT  = 4;
    localparam int POS_BP   = 2;
    localparam int POS_WEL  = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_WDATA,
        PH_RDATA,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] wdt;
        logic [1:0] bp;
        logic       wel;
    } stat_t;

endpackage

// File: rtl/spi_stat_front.sv
module spi_stat_front
    import spi_stat_pkg::*;
#(
    parameter int BYTE_W = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              csn,
    input  logic              si,
    input  logic              sys_rst,
    input  logic [BYTE_W-1:0] stat_byte,
    output logic              so,
    output logic              so_oe,
    output logic              cmd_wren,
    output logic              cmd_wrdi,
    output logic              cmd_wrsr,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam int              CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-2:0] sh;
        logic              sck;
        logic              csn;
        logic              so;
    } fe_t;

    fe_t fe_d, fe_q;
    logic rise, fall, cs_fall;

    always_comb begin
        fe_d     = fe_q;
        cmd_wren = 1'b0;
        cmd_wrdi = 1'b0;
        cmd_wrsr = 1'b0;
        wr_byte  = {fe_q.sh, si};
        rise     = sck & ~fe_q.sck;
        fall     = ~sck & fe_q.sck;
        cs_fall  = fe_q.csn & ~csn;
        fe_d.sck = sck;
        fe_d.csn = csn;

        if (sys_rst || csn) begin
            fe_d.ph  = PH_IDLE;
            fe_d.cnt = '0;
        end else if (cs_fall) begin
            fe_d.ph  = PH_CMD;
            fe_d.cnt = '0;
        end else begin
            case (fe_q.ph)
                PH_CMD, PH_WDATA: begin
                    if (rise) begin
                        fe_d.sh  = wr_byte[BYTE_W-2:0];
                        fe_d.cnt = fe_q.cnt + CNT_W'(1);
                        if (fe_q.cnt == LAST) begin
                            fe_d.cnt = '0;
                            fe_d.ph  = PH_HOLD;
                            if (fe_q.ph == PH_WDATA) begin
                                cmd_wrsr = 1'b1;
                            end else begin
                                case (wr_byte)
                                    CMD_WREN: cmd_wren = 1'b1;
                                    CMD_WRDI: cmd_wrdi = 1'b1;
                                    CMD_RDSR: fe_d.ph  = PH_RDATA;
                                    CMD_WRSR: fe_d.ph  = PH_WDATA;
                                    default:  fe_d.ph  = PH_HOLD;
                                endcase
                            end
                        end
                    end
                end
                PH_RDATA: begin
                    if (fall) begin
                        fe_d.so  = stat_byte[LAST - fe_q.cnt];
                        fe_d.cnt = (fe_q.cnt == LAST) ? '0 : fe_q.cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q.ph  <= PH_IDLE;
            fe_q.cnt <= '0;
            fe_q.sh  <= '0;
            fe_q.sck <= 1'b0;
            fe_q.csn <= 1'b0;   // low at reset: a select already low is not a fresh fall
            fe_q.so  <= 1'b0;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign so    = fe_q.so;
    assign so_oe = (fe_q.ph == PH_RDATA) && !csn && !sys_rst;

endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
    import spi_stat_pkg::*;
#(
    parameter logic [1:0] RST_WDT = 2'b11,
    parameter logic [1:0] RST_BP  = 2'b00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wren,
    input  logic         cmd_wrdi,
    input  logic         cmd_wrsr,
    input  logic         new_lock,
    input  logic [1:0]   new_wdt,
    input  logic [1:0]   new_bp,
    input  logic         wp_n,
    output logic [FRAME_W-1:0] stat_byte,
    output logic         wp_en,
    output logic [1:0]   wdt_period,
    output logic [1:0]   blk_prot
);

    stat_t st_d, st_q;
    logic  frozen;

    always_comb begin
        st_d   = st_q;
        frozen = st_q.lock && !wp_n;
        if (cmd_wren) st_d.wel = 1'b1;
        if (cmd_wrdi) st_d.wel = 1'b0;
        if (cmd_wrsr) begin
            if (st_q.wel && !frozen) begin
                st_d.lock = new_lock;
                st_d.wdt  = new_wdt;
                st_d.bp   = new_bp;
            end
            st_d.wel = 1'b0;
        end

        stat_byte             = '0;
        stat_byte[POS_LOCK]   = st_q.lock;
        stat_byte[POS_WDT+:2] = st_q.wdt;
        stat_byte[POS_BP+:2]  = st_q.bp;
        stat_byte[POS_WEL]    = st_q.wel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= 1'b0;
            st_q.wdt  <= RST_WDT;
            st_q.bp   <= RST_BP;
            st_q.wel  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wp_en      = st_q.lock;
    assign wdt_period = st_q.wdt;
    assign blk_prot   = st_q.bp;

endmodule

// File: rtl/spi_status_lock.sv
module spi_status_lock
    import spi_stat_pkg::*;
#(
    parameter logic [1:0] RST_WDT = 2'b11,
    parameter logic [1:0] RST_BP  = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       csn,
    input  logic       si,
    input  logic       wp_n,
    input  logic       sys_rst,
    output logic       so,
    output logic       so_oe,
    output logic       wp_en,
    output logic [1:0] wdt_period,
    output logic [1:0] blk_prot
);

    logic               cmd_wren, cmd_wrdi, cmd_wrsr;
    logic [FRAME_W-1:0] wr_byte, stat_byte;

    spi_stat_front #(.BYTE_W(FRAME_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .csn       (csn),
        .si        (si),
        .sys_rst   (sys_rst),
        .stat_byte (stat_byte),
        .so        (so),
        .so_oe     (so_oe),
        .cmd_wren  (cmd_wren),
        .cmd_wrdi  (cmd_wrdi),
        .cmd_wrsr  (cmd_wrsr),
        .wr_byte   (wr_byte)
    );

    spi_stat_regs #(.RST_WDT(RST_WDT), .RST_BP(RST_BP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wren   (cmd_wren),
        .cmd_wrdi   (cmd_wrdi),
        .cmd_wrsr   (cmd_wrsr),
        .new_lock   (wr_byte[POS_LOCK]),
        .new_wdt    (wr_byte[POS_WDT+:2]),
        .new_bp     (wr_byte[POS_BP+:2]),
        .wp_n       (wp_n),
        .stat_byte  (stat_byte),
        .wp_en      (wp_en),
        .wdt_period (wdt_period),
        .blk_prot   (blk_prot)
    );

endmodule

// File: rtl/spi_status_lock_chk.sv
module spi_status_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       csn,
    input logic       wp_n,
    input logic       sys_rst,
    input logic       so_oe,
    input logic       wp_en,
    input logic [1:0] wdt_period,
    input logic [1:0] blk_prot
);

    AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !csn) else $error("so_oe while deselected"); // R7

    AST_IDLE_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> ($stable(wdt_period) && $stable(blk_prot) && $stable(wp_en)))
        else $error("field moved while deselected"); // R7

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_en && !wp_n) |=> ($stable(wdt_period) && $stable(blk_prot) && $stable(wp_en)))
        else $error("locked field changed"); // R6

    AST_SYSRST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> ($stable(wdt_period) && $stable(blk_prot) && $stable(wp_en)))
        else $error("field changed during system reset"); // R9

    AST_SYSRST_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> !so_oe) else $error("so_oe during system reset"); // R9

endmodule

bind spi_status_lock spi_status_lock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn        (csn),
    .wp_n       (wp_n),
    .sys_rst    (sys_rst),
    .so_oe      (so_oe),
    .wp_en      (wp_en),
    .wdt_period (wdt_period),
    .blk_prot   (blk_prot)
);

// File: tb/tb_spi_status_lock.sv
module tb_spi_status_lock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, csn = 1'b0, si = 1'b0, wp_n = 1'b1, sys_rst = 1'b0;
    logic       so, so_oe, wp_en;
    logic [1:0] wdt_period, blk_prot;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  mode3 = 1'b0;
    bit  done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    // bench model of the register, from the requirements
    logic       m_lock = 1'b0, m_wel = 1'b0;
    logic [1:0] m_wdt = 2'b11, m_bp = 2'b00;

    always #10 clk = ~clk;

    spi_status_lock dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .si(si),
        .wp_n(wp_n), .sys_rst(sys_rst), .so(so), .so_oe(so_oe),
        .wp_en(wp_en), .wdt_period(wdt_period), .blk_prot(blk_prot)
    );

    function automatic logic [7:0] model_byte();
        return {m_lock, 1'b0, m_wdt, m_bp, m_wel, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_fields(input string tag);
        check(tag, {3'b0, wp_en, wdt_period, blk_prot}, {3'b0, m_lock, m_wdt, m_bp});
    endtask

    task automatic hc();
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0;
            si  = tx[7-i];
            hc();
            rx[7-i] = so;
            sck = 1'b1;
            hc();
        end
        if (!mode3) begin
            sck = 1'b0;
            hc();
        end
    endtask

    task automatic sel();
        sck = mode3;
        hc();
        csn = 1'b0;
        hc();
    endtask

    task automatic desel();
        sck = mode3;
        hc();
        csn = 1'b1;
        hc();
        hc();
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, 8, r); desel();
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [7:0] dat);
        logic [7:0] r;
        sel(); xfer(op, 8, r); xfer(dat, 8, r); desel();
    endtask

    // driver: pushes expected status bytes, the monitor pops and compares
    task automatic rdsr(input int nbytes, input string tag);
        logic [7:0] r;
        sel();
        xfer(8'h05, 8, r);
        for (int k = 0; k < nbytes; k++) begin
            exp_q.push_back(model_byte());
            tag_q.push_back(tag);
            xfer(8'h00, 8, r);
            got_q.push_back(r);
        end
        desel();
    endtask

    task automatic write_model(input logic [7:0] dat);
        if (m_wel && !(m_lock && !wp_n)) begin
            m_lock = dat[7];
            m_wdt  = dat[5:4];
            m_bp   = dat[3:2];
        end
        m_wel = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && got_q.size() > 0) begin
                check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hc();
        check_fields("R1 reset fields");
        check("R1 so_oe at reset", {7'b0, so_oe}, 8'h00);

        // csn low since reset: no fresh fall, nothing decoded
        xfer(8'h06, 8, r); xfer(8'h01, 8, r); xfer(8'h3C, 8, r);
        csn = 1'b1; hc(); hc();
        check_fields("R8 no decode before select fall");
        rdsr(1, "R8 latch still clear");

        // output enable only in read phase
        sel(); xfer(8'h05, 8, r);
        check("R7 so_oe in read phase", {7'b0, so_oe}, 8'h01);
        desel();
        check("R7 so_oe after deselect", {7'b0, so_oe}, 8'h00);

        cmd2(8'h01, 8'h14); write_model(8'h14);
        check_fields("R5 write without latch ignored");

        cmd1(8'h06); m_wel = 1'b1;
        rdsr(1, "R3 WREN sets latch");
        cmd1(8'h04); m_wel = 1'b0;
        rdsr(1, "R3 WRDI clears latch");

        cmd1(8'h06); m_wel = 1'b1;
        cmd2(8'h01, 8'h94); write_model(8'h94);
        check_fields("R5 write with latch");
        rdsr(1, "R5 latch cleared after write");

        wp_n = 1'b0;
        cmd1(8'h06); m_wel = 1'b1;
        cmd2(8'h01, 8'h28); write_model(8'h28);
        check_fields("R6 locked write ignored");
        rdsr(1, "R6 locked write clears latch");

        wp_n = 1'b1;
        cmd1(8'h06); m_wel = 1'b1;
        cmd2(8'h01, 8'h08); write_model(8'h08);
        check_fields("R6 pin high write accepted");
        wp_n = 1'b0;
        cmd1(8'h06); m_wel = 1'b1;
        cmd2(8'h01, 8'h20); write_model(8'h20);
        check_fields("R6 lock bit clear write accepted");
        wp_n = 1'b1;

        // aborted bytes
        cmd1(8'h06); m_wel = 1'b1;
        sel(); xfer(8'h01, 8, r); xfer(8'hFF, 4, r); desel();
        check_fields("R10 cut data byte discarded");
        sel(); xfer(8'h04, 5, r); desel();
        rdsr(1, "R10 cut command discarded");

        // system reset blocks traffic
        sys_rst = 1'b1;
        cmd2(8'h01, 8'hFC);
        check_fields("R9 write during sys_rst ignored");
        sel(); xfer(8'h05, 8, r);
        check("R9 so_oe during sys_rst", {7'b0, so_oe}, 8'h00);
        desel();
        sys_rst = 1'b0;
        sel(); xfer(8'h01, 8, r);
        sys_rst = 1'b1; hc(); sys_rst = 1'b0;
        xfer(8'hFC, 8, r); desel();
        check_fields("R9 aborted by sys_rst pulse");
        rdsr(1, "R9 latch kept");

        sel(); xfer(8'h9F, 8, r); xfer(8'hFC, 8, r); desel();
        check_fields("R11 unknown command ignored");
        rdsr(1, "R11 latch kept");

        mode3 = 1'b1;
        cmd2(8'h01, 8'hBC); write_model(8'hBC);
        check_fields("R2 mode 3 write");
        rdsr(2, "R2 R4 mode 3 repeated read");
        mode3 = 1'b0;
        rdsr(3, "R4 mode 0 repeated read");

        repeat (10) @(negedge clk);
        if (exp_q.size() != got_q.size()) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 scoreboard: actual %0d left expected %0d left", got_q.size(), exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule